// File: doc/BRIEF.md
# Nested Window Range Clipper

This block narrows a device's resource range to the part that every bridge above the device actually forwards. A request gives a start address, a size and a space selector (I/O or memory), plus the decode-enable bits for both spaces. The caller also presents one window (lowest forwarded address and highest forwarded address) per bridge level, packed into flat vectors, and a count of how many levels are valid.

After a start pulse the block walks the levels one per clock cycle. It keeps a running lower bound and a running upper bound: each level can only raise the lower bound and lower the upper bound. When the walk ends, it registers the clipped start and size, or an unmapped result. It raises a one-cycle done strobe. It also flags whether the new result differs from the mapping it stored last time, and the new result replaces the stored one. Decoding the bridges' window registers, and routing any address, are left to the caller.

Top module: `nested_window_clipper`

## Requirements
- R1: On acceptance the running range is lower = `res_addr_i` and upper = `res_addr_i + res_size_i - 1`. With zero valid levels and decoding enabled, the result is exactly the requested start and size.
- R2: For each processed level k, the lower bound becomes the larger of itself and the window base. The base is `win_lo_i[k*ADDR_W +: ADDR_W]`.
- R3: For each processed level k, the upper bound becomes the smaller of itself and the window limit. The limit is `win_hi_i[k*ADDR_W +: ADDR_W]`.
- R4: The space is selected by `sel_io_i`: 1 means I/O and is gated by `io_dec_en_i`, and 0 means memory and is gated by `mem_dec_en_i`. If the gate for the selected space is 0, the result is unmapped, whatever the windows hold.
- R5: If the final lower bound exceeds the final upper bound, the result is unmapped. Every unmapped result has `map_addr_o` all ones, `map_size_o` zero and `map_none_o` = 1.
- R6: Otherwise `map_addr_o` = lower bound, `map_size_o` = upper - lower + 1, and `map_none_o` = 0.
- R7: A request whose `res_addr_i` is all ones is already unmapped. It skips every level and yields an unmapped result.
- R8: `changed_o`, valid with `done_o`, is 1 exactly when the new start or the new size differs from the stored mapping. The stored mapping then takes the new values. The stored mapping after reset is unmapped.
- R9: A start pulse while `busy_o` is high has no effect on the request in flight or on its result.
- R10: The start is accepted at a clock edge where the block is idle and `start_i` is 1. For L effective levels, `busy_o` is high for L+1 cycles and `done_o` is high for exactly one cycle after that. L is 0 for a skipped or disabled request. A new start may be accepted in the done cycle.
- R11: After reset, `busy_o`, `done_o` and `changed_o` are 0, and the outputs show the unmapped result.
- R12: Only the first `lvl_cnt_i` levels are used, and a count above MAX_LVL is treated as MAX_LVL. Windows of levels beyond the count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request start pulse |
| res_addr_i | input | ADDR_W | Requested start address (all ones = unmapped) |
| res_size_i | input | ADDR_W | Requested size, nonzero |
| sel_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| io_dec_en_i | input | 1 | I/O decode enable |
| mem_dec_en_i | input | 1 | Memory decode enable |
| lvl_cnt_i | input | CNT_W | Number of valid bridge levels |
| win_lo_i | input | MAX_LVL*ADDR_W | Window bases, level k at bits k*ADDR_W |
| win_hi_i | input | MAX_LVL*ADDR_W | Window limits, level k at bits k*ADDR_W |
| busy_o | output | 1 | Request in flight |
| done_o | output | 1 | One-cycle completion strobe |
| map_addr_o | output | ADDR_W | Clipped start, all ones when unmapped |
| map_size_o | output | ADDR_W | Clipped size, zero when unmapped |
| map_none_o | output | 1 | Result is unmapped |
| changed_o | output | 1 | Result differs from the stored mapping |

## Verification
Some rules are checked by the assertions on every cycle:
- the running bounds only ever narrow while levels are walked;
- the level index stays below the effective count, and the walk is not disturbed by start pulses;
- done is never longer than one cycle;
- an unmapped result always carries the all-ones start and zero size;
- the change flag agrees with whether the outputs actually moved.

The exact clipped values need the bench's reference model, and so does the latency per level count. So do the selection between the I/O and memory enables, the clamping of oversized counts, and the indifference to windows beyond the count. The bench compares against its model every clock.

// File: rtl/nwc_pkg.sv
package nwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } nwc_state_e;
endpackage

// File: rtl/nwc_ctrl.sv
module nwc_ctrl
  import nwc_pkg::*;
#(
  parameter int MAX_LVL = 4,
  localparam int CNT_W  = $clog2(MAX_LVL + 1),
  localparam int IDX_W  = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] lvl_cnt_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             step_o,
  output logic             fin_o,
  output logic [IDX_W-1:0] lvl_o
);
  nwc_state_e       state_q, state_d;
  logic [IDX_W-1:0] lvl_q, lvl_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic [CNT_W-1:0] eff_cnt;

  // effective level count: zero when the request skips, clamped to MAX_LVL
  always_comb begin
    if (skip_i)
      eff_cnt = '0;
    else if (lvl_cnt_i > CNT_W'(MAX_LVL))
      eff_cnt = CNT_W'(MAX_LVL);
    else
      eff_cnt = lvl_cnt_i;
  end

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    last_d  = last_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          last_d  = eff_cnt;
          lvl_d   = '0;
          state_d = (eff_cnt == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (CNT_W'(lvl_q) == last_q - CNT_W'(1))
          state_d = ST_FIN;
        else
          lvl_d = lvl_q + IDX_W'(1);
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      last_q  <= last_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
  assign lvl_o  = lvl_q;

  // R12: walked index stays inside the effective count
  p_lvl_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (CNT_W'(lvl_q) < last_q));

  // R9: a start pulse during the walk does not disturb the level sequence
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start_i) |=>
      (state_q == ST_FIN || lvl_q == $past(lvl_q) + IDX_W'(1)));

  // R9: the effective count is frozen while busy
  p_count_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(last_q));
endmodule

// File: rtl/nwc_range.sv
module nwc_range #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LVL = 4,
  localparam int IDX_W  = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic                      step_i,
  input  logic                      skip_i,
  input  logic [IDX_W-1:0]          lvl_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [ADDR_W-1:0]         size_i,
  input  logic [MAX_LVL*ADDR_W-1:0] win_lo_i,
  input  logic [MAX_LVL*ADDR_W-1:0] win_hi_i,
  output logic [ADDR_W-1:0]         lo_o,
  output logic [ADDR_W-1:0]         hi_o,
  output logic                      kill_o
);
  logic [ADDR_W-1:0] lo_arr [MAX_LVL];
  logic [ADDR_W-1:0] hi_arr [MAX_LVL];

  for (genvar g = 0; g < MAX_LVL; g++) begin : g_unpack
    assign lo_arr[g] = win_lo_i[g*ADDR_W +: ADDR_W];
    assign hi_arr[g] = win_hi_i[g*ADDR_W +: ADDR_W];
  end

  logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              kill_q, kill_d;
  logic [ADDR_W-1:0] cur_lo, cur_hi;

  assign cur_lo = lo_arr[lvl_i];
  assign cur_hi = hi_arr[lvl_i];

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    kill_d = kill_q;
    if (load_i) begin
      lo_d   = addr_i;
      hi_d   = addr_i + size_i - ADDR_W'(1);
      kill_d = skip_i;
    end else if (step_i) begin
      lo_d = (cur_lo > lo_q) ? cur_lo : lo_q;
      hi_d = (cur_hi < hi_q) ? cur_hi : hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      kill_q <= 1'b0;
    end else if (load_i || step_i) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      kill_q <= kill_d;
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign kill_o = kill_q;

  // R2: a level can only raise the lower bound
  p_lo_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (lo_q >= $past(lo_q)));

  // R3: a level can only lower the upper bound
  p_hi_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (hi_q <= $past(hi_q)));
endmodule

// File: rtl/nwc_result.sv
module nwc_result #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_i,
  input  logic              kill_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] size_o,
  output logic              none_o,
  output logic              chg_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, size_q, size_d;
  logic              none_q, none_d, chg_q, chg_d, done_q;
  logic              empty;

  assign empty = kill_i || (lo_i > hi_i);

  always_comb begin
    addr_d = addr_q;
    size_d = size_q;
    none_d = none_q;
    chg_d  = 1'b0;
    if (fin_i) begin
      none_d = empty;
      addr_d = empty ? '1 : lo_i;
      size_d = empty ? '0 : (hi_i - lo_i + ADDR_W'(1));
      chg_d  = (addr_d != addr_q) || (size_d != size_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '1;
      size_q <= '0;
      none_q <= 1'b1;
      chg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_i;
      chg_q  <= chg_d;
      if (fin_i) begin
        addr_q <= addr_d;
        size_q <= size_d;
        none_q <= none_d;
      end
    end
  end

  assign done_o = done_q;
  assign addr_o = addr_q;
  assign size_o = size_q;
  assign none_o = none_q;
  assign chg_o  = chg_q;

  // R10: done is a single-cycle strobe
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: unmapped results carry the marker start and zero size
  p_none_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    none_q |-> (addr_q == '1 && size_q == '0));

  // R8: a reported change means the outputs moved
  p_chg_moved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && chg_q) |-> (addr_q != $past(addr_q) || size_q != $past(size_q)));

  // R8: no reported change means the outputs held
  p_chg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !chg_q) |-> ($stable(addr_q) && $stable(size_q)));

  // R8: change flag only accompanies done
  p_chg_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> done_q);
endmodule

// File: rtl/nested_window_clipper.sv
module nested_window_clipper #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LVL = 4,
  localparam int CNT_W  = $clog2(MAX_LVL + 1),
  localparam int IDX_W  = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         res_addr_i,
  input  logic [ADDR_W-1:0]         res_size_i,
  input  logic                      sel_io_i,
  input  logic                      io_dec_en_i,
  input  logic                      mem_dec_en_i,
  input  logic [CNT_W-1:0]          lvl_cnt_i,
  input  logic [MAX_LVL*ADDR_W-1:0] win_lo_i,
  input  logic [MAX_LVL*ADDR_W-1:0] win_hi_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [ADDR_W-1:0]         map_addr_o,
  output logic [ADDR_W-1:0]         map_size_o,
  output logic                      map_none_o,
  output logic                      changed_o
);
  logic             dec_off, in_none, skip;
  logic             load, step, fin, kill;
  logic [IDX_W-1:0] lvl;
  logic [ADDR_W-1:0] lo, hi;

  // R4: the selected space's enable gates the whole request
  assign dec_off = sel_io_i ? !io_dec_en_i : !mem_dec_en_i;
  // R7: an all-ones start is already unmapped
  assign in_none = (res_addr_i == '1);
  assign skip    = dec_off || in_none;

  nwc_ctrl #(.MAX_LVL(MAX_LVL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .skip_i    (skip),
    .lvl_cnt_i (lvl_cnt_i),
    .busy_o    (busy_o),
    .load_o    (load),
    .step_o    (step),
    .fin_o     (fin),
    .lvl_o     (lvl)
  );

  nwc_range #(.ADDR_W(ADDR_W), .MAX_LVL(MAX_LVL)) u_range (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .skip_i   (skip),
    .lvl_i    (lvl),
    .addr_i   (res_addr_i),
    .size_i   (res_size_i),
    .win_lo_i (win_lo_i),
    .win_hi_i (win_hi_i),
    .lo_o     (lo),
    .hi_o     (hi),
    .kill_o   (kill)
  );

  nwc_result #(.ADDR_W(ADDR_W)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .fin_i  (fin),
    .kill_i (kill),
    .lo_i   (lo),
    .hi_i   (hi),
    .done_o (done_o),
    .addr_o (map_addr_o),
    .size_o (map_size_o),
    .none_o (map_none_o),
    .chg_o  (changed_o)
  );

  // R10: done never coincides with an active walk
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !step);
endmodule

// File: tb/nested_window_clipper_tb.sv
module nested_window_clipper_tb;
  localparam int AW = 32;
  localparam int ML = 4;
  localparam int CW = $clog2(ML + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [AW-1:0]     res_addr_i = '0;
  logic [AW-1:0]     res_size_i = '0;
  logic              sel_io_i = 1'b0;
  logic              io_dec_en_i = 1'b1;
  logic              mem_dec_en_i = 1'b1;
  logic [CW-1:0]     lvl_cnt_i = '0;
  logic [ML*AW-1:0]  win_lo_i = '0;
  logic [ML*AW-1:0]  win_hi_i = '0;
  logic              busy_o, done_o, map_none_o, changed_o;
  logic [AW-1:0]     map_addr_o, map_size_o;

  always #10 clk = ~clk;

  nested_window_clipper #(.ADDR_W(AW), .MAX_LVL(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .res_addr_i(res_addr_i), .res_size_i(res_size_i),
    .sel_io_i(sel_io_i), .io_dec_en_i(io_dec_en_i), .mem_dec_en_i(mem_dec_en_i),
    .lvl_cnt_i(lvl_cnt_i), .win_lo_i(win_lo_i), .win_hi_i(win_hi_i),
    .busy_o(busy_o), .done_o(done_o), .map_addr_o(map_addr_o),
    .map_size_o(map_size_o), .map_none_o(map_none_o), .changed_o(changed_o)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R11";

  // reference model state
  int            rem = 0;
  logic          m_done = 0, m_chg = 0, m_none = 1;
  logic [AW-1:0] m_addr = '1, m_size = '0;
  logic [AW-1:0] p_addr, p_size;
  logic          p_none;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem = 0; m_done = 0; m_chg = 0; m_none = 1; m_addr = '1; m_size = '0;
    end else begin
      m_done = 0;
      m_chg  = 0;
      if (rem > 0) begin
        rem = rem - 1;
        if (rem == 0) begin
          m_done = 1;
          m_chg  = (p_addr != m_addr) || (p_size != m_size);
          m_addr = p_addr; m_size = p_size; m_none = p_none;
        end
      end else if (start_i) begin
        longint unsigned s, e, b, l;
        int n;
        bit skip;
        skip = (res_addr_i == '1) || (sel_io_i ? !io_dec_en_i : !mem_dec_en_i);
        n = (int'(lvl_cnt_i) > ML) ? ML : int'(lvl_cnt_i);
        if (skip) n = 0;
        s = res_addr_i;
        e = longint'(res_addr_i) + longint'(res_size_i) - 1;
        for (int i = 0; i < n; i++) begin
          b = win_lo_i[i*AW +: AW];
          l = win_hi_i[i*AW +: AW];
          if (b > s) s = b;
          if (l < e) e = l;
        end
        if (skip || s > e) begin
          p_none = 1; p_addr = '1; p_size = '0;
        end else begin
          p_none = 0; p_addr = s[AW-1:0]; p_size = AW'(e - s + 1);
        end
        rem = n + 1;
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("busy (R10)", busy_o, rem > 0);
      chk("done (R10)", done_o, m_done);
      chk("addr (R6)", map_addr_o, m_addr);
      chk("size (R6)", map_size_o, m_size);
      chk("none (R5)", map_none_o, m_none);
      chk("changed (R8)", changed_o, m_chg);
    end
  end

  task automatic set_win(input int k, input logic [AW-1:0] b, input logic [AW-1:0] l);
    win_lo_i[k*AW +: AW] = b;
    win_hi_i[k*AW +: AW] = l;
  endtask

  // called at a negedge; drives a one-cycle start
  task automatic go(input logic [AW-1:0] a, input logic [AW-1:0] sz,
                    input logic io, input logic ioe, input logic me, input int cnt);
    res_addr_i = a; res_size_i = sz; sel_io_i = io;
    io_dec_en_i = ioe; mem_dec_en_i = me; lvl_cnt_i = CW'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) begin
      errors++;
      $display("FAIL %s done never seen: actual=0 expected=1", cur_req);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < ML; k++) set_win(k, 32'h0, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("reset busy R11", busy_o, 0);
    chk("reset done R11", done_o, 0);
    chk("reset addr R11", map_addr_o, 32'hFFFF_FFFF);
    chk("reset size R11", map_size_o, 0);
    chk("reset changed R11", changed_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1"; // no levels: result equals request
    go(32'h1000, 32'h100, 0, 1, 1, 0); wait_done(); @(negedge clk);
    cur_req = "R8"; // same request again: no change
    go(32'h1000, 32'h100, 0, 1, 1, 0); wait_done();
    chk("repeat unchanged R8", changed_o, 0);
    @(negedge clk);

    cur_req = "R2"; // bases raise the start
    set_win(0, 32'h1040, 32'hFFFF); set_win(1, 32'h1080, 32'hFFFF);
    go(32'h1000, 32'h100, 0, 1, 1, 2); wait_done();
    chk("clipped start R2", map_addr_o, 32'h1080);
    chk("clipped size R6", map_size_o, 32'h80);
    @(negedge clk);

    cur_req = "R3"; // limits lower the end across four levels
    set_win(0, 32'h0, 32'h10FF); set_win(1, 32'h0, 32'h10C0);
    set_win(2, 32'h1010, 32'h10A0); set_win(3, 32'h0, 32'h10B0);
    go(32'h1000, 32'h100, 0, 1, 1, 4); wait_done(); @(negedge clk);

    cur_req = "R5"; // disjoint window collapses the range
    set_win(0, 32'h2000, 32'h2FFF);
    go(32'h1000, 32'h100, 0, 1, 1, 1); wait_done();
    chk("collapse none R5", map_none_o, 1);
    @(negedge clk);

    cur_req = "R4"; // I/O with I/O decode off
    for (int k = 0; k < ML; k++) set_win(k, 32'h0, 32'hFFFF_FFFF);
    go(32'h300, 32'h10, 1, 0, 1, 2); wait_done(); @(negedge clk);
    cur_req = "R4"; // memory with only I/O decode off stays mapped
    go(32'h300, 32'h10, 0, 0, 1, 2); wait_done();
    chk("mem mapped R4", map_none_o, 0);
    @(negedge clk);
    cur_req = "R4"; // memory decode off
    go(32'h300, 32'h10, 0, 1, 0, 3); wait_done(); @(negedge clk);

    cur_req = "R7"; // unmapped input skips levels
    go(32'h300, 32'h10, 0, 1, 1, 2); wait_done(); @(negedge clk);
    go(32'hFFFF_FFFF, 32'h10, 0, 1, 1, 4); wait_done(); @(negedge clk);

    cur_req = "R9"; // start pulses while busy are ignored
    set_win(0, 32'h5000, 32'h5FFF);
    go(32'h5800, 32'h1000, 0, 1, 1, 4);
    res_addr_i = 32'h7000; start_i = 1'b1;
    @(negedge clk); @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk("busy start ignored R9", map_addr_o, 32'h5800);
    @(negedge clk);

    cur_req = "R12"; // level beyond count and oversized count
    set_win(0, 32'h0, 32'hFFFF_FFFF);
    set_win(3, 32'h9000, 32'h9FFF);
    go(32'h100, 32'h100, 0, 1, 1, 3); wait_done();
    chk("level 3 ignored R12", map_addr_o, 32'h100);
    @(negedge clk);
    go(32'h100, 32'h100, 0, 1, 1, 7); wait_done(); @(negedge clk);

    cur_req = "R10"; // back-to-back start in the done cycle
    for (int k = 0; k < ML; k++) set_win(k, 32'h0, 32'hFFFF_FFFF);
    go(32'h4000, 32'h40, 0, 1, 1, 1); wait_done();
    go(32'h4400, 32'h40, 0, 1, 1, 0); wait_done();
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule